// File: doc/BRIEF.md
# SPI Receive Status and Error Flag Register

This block holds the status and control register of a serial peripheral whose receiver is double-buffered. The shift engine reports these events as single-cycle strobes:

- a completed byte, with its value;
- a write into the transmit buffer;
- the transmit buffer moving into the shift register.

It also gives two levels: whether a transfer is in progress, and the current level of the select pin. The bus side gives a read strobe for the status register, a read strobe for the receive data register, and a write port for the control bits.

The block keeps the receive data register and three sticky error and receive flags. It tracks the transmit-empty condition. It drives the receive and error interrupt requests and holds the two baud-select bits for the clock generator.

Each flag clears only through an ordered pair of accesses. First the status register is read while the flag is set. Then a second access clears it:
- a data read clears receive-full and overflow;
- a control write clears mode-fault.

When the receive register is still full, a new byte is dropped and the old byte is kept. A select-pin fault is detected one way in slave mode and another way in master mode.

Top module: `spiStatusTop`

## Requirements
- R1: A byteDone strobe with the receive register empty loads rxShiftByte into rxData and sets receive-full (status bit 7) on the next clock edge.
- R2: Receive-full clears only when a statusRd while it is set is followed later by a dataRd. A dataRd without that earlier status read leaves it set.
- R3: A byteDone while receive-full is set, and not being cleared in that cycle, sets overflow (status bit 5). rxData keeps the old byte and the new byte is discarded.
- R4: Overflow clears by a statusRd while it is set, followed by a dataRd.
- R5: With mode-fault enable (status bit 2) set, mode-fault (status bit 4) sets under two conditions. In slave mode (masterMode=0) it sets on a rising edge of selLevel while xferActive is 1. In master mode it sets on any falling edge of selLevel. With the enable clear, neither edge sets it.
- R6: rxIrq equals receive-full AND rxIntEn. errIrq equals error-interrupt-enable (status bit 6) AND (overflow OR mode-fault).
- R7: The status byte is laid out, bit 7 down to bit 0, as: receive-full, error-interrupt-enable, overflow, mode-fault, transmit-empty, mode-fault-enable, baud1, baud0. After reset it reads 0x08. A control write updates only bits 6, 2, 1 and 0; the flag bits ignore the written data.
- R8: Transmit-empty (status bit 3) clears on txLoad and sets on txToShift.
- R9: When a flag's set event and its clearing access fall in the same cycle, the flag stays set. A byte that arrives in the same cycle as a clearing data read is loaded and does not raise overflow.
- R10: Mode-fault clears when a statusRd while it is set is followed by a ctrlWr. A ctrlWr without that earlier status read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteDone | input | 1 | Shift engine finished a received byte |
| rxShiftByte | input | 8 | Byte just received by the shift engine |
| txLoad | input | 1 | Write into the transmit buffer |
| txToShift | input | 1 | Transmit buffer moved into the shift register |
| xferActive | input | 1 | A transfer is in progress |
| selLevel | input | 1 | Current level of the select pin |
| masterMode | input | 1 | 1 when the peripheral is the master |
| rxIntEn | input | 1 | Receive interrupt enable |
| statusRd | input | 1 | Bus read of the status register |
| dataRd | input | 1 | Bus read of the receive data register |
| ctrlWr | input | 1 | Bus write of the control bits |
| ctrlWrData | input | 8 | Write data, using the status byte layout |
| statusByte | output | 8 | Status register read value |
| rxData | output | 8 | Receive data register |
| baudSel | output | 2 | Baud-select bits |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
The bench first checks that a lone data read or a lone control write leaves a flag set. A design that cleared on the second access alone would drop that flag.

It then fills the receive register twice without a read. This confirms that the first byte survives and the overflow flag rises; a design that overwrote the register would show the second byte.

A byte is made to arrive in the same cycle as the clearing data read. A design where the clear won, or that flagged that byte as an overflow, would read back receive-full low or overflow high.

Select-pin edges are applied in both modes, with and without a transfer in progress and with detection disabled. A design with the slave and master rules swapped, or that ignored the enable, would raise the fault in the wrong case.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  // Strobes handed from the flag control to the datapath.
  typedef struct packed {
    logic loadRx;   // accept the completed byte into the receive register
    logic wrCtrl;   // update the writable control bits
  } dpStrobe_t;

  // Bit positions inside the status byte.
  localparam int STAT_RXF  = 7;
  localparam int STAT_EIE  = 6;
  localparam int STAT_OVF  = 5;
  localparam int STAT_MF   = 4;
  localparam int STAT_TXE  = 3;
  localparam int STAT_MFEN = 2;
  localparam int STAT_BAUD = 0;
  localparam int BAUD_W    = 2;
endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      byteDone,
  input  logic      txLoad,
  input  logic      txToShift,
  input  logic      xferActive,
  input  logic      selLevel,
  input  logic      masterMode,
  input  logic      statusRd,
  input  logic      dataRd,
  input  logic      ctrlWr,
  input  logic      mfEn,
  output logic      rxFull,
  output logic      ovfFlag,
  output logic      mfFlag,
  output logic      txEmpty,
  output dpStrobe_t strobe
);
  logic selPrev;
  logic armRx, armOvf, armMf;
  logic selRise, selFall, mfEvent;
  logic clrRx, clrOvf, clrMf, ovfEvent;

  assign selRise  = selLevel & ~selPrev;
  assign selFall  = ~selLevel & selPrev;
  assign mfEvent  = mfEn & (masterMode ? selFall : (selRise & xferActive));
  assign clrRx    = dataRd & armRx;
  assign clrOvf   = dataRd & armOvf;
  assign clrMf    = ctrlWr & armMf;
  assign ovfEvent = byteDone & rxFull & ~clrRx;

  assign strobe.loadRx = byteDone & (~rxFull | clrRx);
  assign strobe.wrCtrl = ctrlWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPrev <= 1'b1;
      rxFull  <= 1'b0;
      ovfFlag <= 1'b0;
      mfFlag  <= 1'b0;
      txEmpty <= 1'b1;
      armRx   <= 1'b0;
      armOvf  <= 1'b0;
      armMf   <= 1'b0;
    end else begin
      selPrev <= selLevel;

      if (byteDone)   rxFull <= 1'b1;
      else if (clrRx) rxFull <= 1'b0;

      if (ovfEvent)    ovfFlag <= 1'b1;
      else if (clrOvf) ovfFlag <= 1'b0;

      if (mfEvent)    mfFlag <= 1'b1;
      else if (clrMf) mfFlag <= 1'b0;

      if (txToShift)   txEmpty <= 1'b1;
      else if (txLoad) txEmpty <= 1'b0;

      if (dataRd)                  armRx <= 1'b0;
      else if (statusRd && rxFull) armRx <= 1'b1;

      if (dataRd)                   armOvf <= 1'b0;
      else if (statusRd && ovfFlag) armOvf <= 1'b1;

      if (ctrlWr)                  armMf <= 1'b0;
      else if (statusRd && mfFlag) armMf <= 1'b1;
    end
  end

  AST_RXF_SETS: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> rxFull); // R1
  AST_RXF_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(dataRd)); // R2
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && rxFull && !dataRd) |=> ovfFlag); // R3
  AST_MF_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mfFlag) |-> $past(ctrlWr)); // R10
  AST_TXE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txToShift |=> txEmpty); // R8
endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rxShiftByte,
  input  logic [7:0]        ctrlWrData,
  output logic [DATA_W-1:0] rxData,
  output logic              errIntEn,
  output logic              mfEn,
  output logic [BAUD_W-1:0] baudSel
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      errIntEn <= 1'b0;
      mfEn     <= 1'b0;
      baudSel  <= '0;
    end else begin
      if (strobe.loadRx) rxData <= rxShiftByte;
      if (strobe.wrCtrl) begin
        errIntEn <= ctrlWrData[STAT_EIE];
        mfEn     <= ctrlWrData[STAT_MFEN];
        baudSel  <= ctrlWrData[STAT_BAUD +: BAUD_W];
      end
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRx |=> $stable(rxData)); // R3
endmodule

// File: rtl/spiStatusTop.sv
module spiStatusTop
  import spi_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxShiftByte,
  input  logic              txLoad,
  input  logic              txToShift,
  input  logic              xferActive,
  input  logic              selLevel,
  input  logic              masterMode,
  input  logic              rxIntEn,
  input  logic              statusRd,
  input  logic              dataRd,
  input  logic              ctrlWr,
  input  logic [7:0]        ctrlWrData,
  output logic [7:0]        statusByte,
  output logic [DATA_W-1:0] rxData,
  output logic [BAUD_W-1:0] baudSel,
  output logic              rxIrq,
  output logic              errIrq
);
  dpStrobe_t strobe;
  logic rxFull, ovfFlag, mfFlag, txEmpty, errIntEn, mfEn;

  spi_stat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .txLoad(txLoad),
    .txToShift(txToShift), .xferActive(xferActive), .selLevel(selLevel),
    .masterMode(masterMode), .statusRd(statusRd), .dataRd(dataRd),
    .ctrlWr(ctrlWr), .mfEn(mfEn), .rxFull(rxFull), .ovfFlag(ovfFlag),
    .mfFlag(mfFlag), .txEmpty(txEmpty), .strobe(strobe)
  );

  spi_stat_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxShiftByte(rxShiftByte),
    .ctrlWrData(ctrlWrData), .rxData(rxData), .errIntEn(errIntEn),
    .mfEn(mfEn), .baudSel(baudSel)
  );

  always_comb begin
    statusByte = '0;
    statusByte[STAT_RXF]  = rxFull;
    statusByte[STAT_EIE]  = errIntEn;
    statusByte[STAT_OVF]  = ovfFlag;
    statusByte[STAT_MF]   = mfFlag;
    statusByte[STAT_TXE]  = txEmpty;
    statusByte[STAT_MFEN] = mfEn;
    statusByte[STAT_BAUD +: BAUD_W] = baudSel;
  end

  assign rxIrq  = rxFull & rxIntEn;
  assign errIrq = errIntEn & (ovfFlag | mfFlag);

  AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> statusByte[STAT_EIE]); // R6
  AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (rxIntEn && statusByte[STAT_RXF])); // R6
endmodule

// File: tb/sim_spiStatusTop.sv
module sim_spiStatusTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteDone = 0, txLoad = 0, txToShift = 0, xferActive = 0;
  logic selLevel = 1, masterMode = 0, rxIntEn = 0;
  logic statusRd = 0, dataRd = 0, ctrlWr = 0;
  logic [7:0] rxShiftByte = 0, ctrlWrData = 0;
  logic [7:0] statusByte, rxData;
  logic [1:0] baudSel;
  logic rxIrq, errIrq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spiStatusTop u0 (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .rxShiftByte(rxShiftByte),
    .txLoad(txLoad), .txToShift(txToShift), .xferActive(xferActive),
    .selLevel(selLevel), .masterMode(masterMode), .rxIntEn(rxIntEn),
    .statusRd(statusRd), .dataRd(dataRd), .ctrlWr(ctrlWr),
    .ctrlWrData(ctrlWrData), .statusByte(statusByte), .rxData(rxData),
    .baudSel(baudSel), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  typedef struct {
    int         kind;   // 0 status, 1 rxData, 2 {errIrq,rxIrq}, 3 baudSel
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  task automatic expect_val(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares expectations shortly after the falling edge.
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = statusByte;
        1: act = rxData;
        2: act = {6'b0, errIrq, rxIrq};
        default: act = {6'b0, baudSel};
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  // One cycle of stimulus; pulses drop at the following falling edge.
  task automatic cyc();
    @(negedge clk);
    byteDone = 0; txLoad = 0; txToShift = 0;
    statusRd = 0; dataRd = 0; ctrlWr = 0;
  endtask

  task automatic rxByte(logic [7:0] b);
    byteDone = 1; rxShiftByte = b; cyc();
  endtask
  task automatic rdStat(); statusRd = 1; cyc(); endtask
  task automatic rdData(); dataRd = 1; cyc(); endtask
  task automatic wrCtl(logic [7:0] d); ctrlWr = 1; ctrlWrData = d; cyc(); endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog actual=hung expected=finished");
          $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rstN = 1;
    expect_val(0, 8'h08, "R7 reset");
    expect_val(1, 8'h00, "R7 reset data");
    expect_val(2, 8'h00, "R6 reset irq");
    cyc();

    // R1
    rxByte(8'hA5);
    expect_val(0, 8'h88, "R1 rxFull set"); expect_val(1, 8'hA5, "R1 data");
    expect_val(2, 8'h00, "R6 rxIrq off");
    // R2: lone data read
    rdData(); expect_val(0, 8'h88, "R2 lone dataRd");
    rdStat(); rdData(); expect_val(0, 8'h08, "R2 sequence clears");
    // R3
    rxByte(8'h11); rxByte(8'h22);
    expect_val(0, 8'hA8, "R3 overflow"); expect_val(1, 8'h11, "R3 old byte kept");
    rdStat(); rdData(); expect_val(0, 8'h08, "R4 overflow cleared");
    // R6 receive interrupt
    rxIntEn = 1;
    rxByte(8'h5A); expect_val(2, 8'h01, "R6 rxIrq");
    rdStat(); rdData(); expect_val(2, 8'h00, "R6 rxIrq clear");
    // R7 read-only flags ignore writes
    wrCtl(8'hFF); expect_val(0, 8'h4F, "R7 ctrl write"); expect_val(3, 8'h03, "R7 baud");
    wrCtl(8'h40); expect_val(0, 8'h48, "R7 ctrl write 2");
    // R9 set wins
    rxByte(8'h33); rdStat();
    dataRd = 1; byteDone = 1; rxShiftByte = 8'h44; cyc();
    expect_val(0, 8'hC8, "R9 set wins"); expect_val(1, 8'h44, "R9 new byte loaded");
    rdStat(); rdData(); expect_val(0, 8'h48, "R2 clear after R9");
    // R5 slave
    wrCtl(8'h44); expect_val(0, 8'h4C, "R5 enable");
    selLevel = 0; cyc(); selLevel = 1; cyc();
    expect_val(0, 8'h4C, "R5 slave rise idle no fault");
    xferActive = 1;
    selLevel = 0; cyc(); expect_val(0, 8'h4C, "R5 slave fall no fault");
    selLevel = 1; cyc();
    expect_val(0, 8'h5C, "R5 slave fault"); expect_val(2, 8'h02, "R6 errIrq mf");
    // R10
    wrCtl(8'h44); expect_val(0, 8'h5C, "R10 lone write");
    rdStat(); wrCtl(8'h44); expect_val(0, 8'h4C, "R10 sequence clears");
    xferActive = 0;
    // R5 master
    masterMode = 1;
    selLevel = 0; cyc(); expect_val(0, 8'h5C, "R5 master fault");
    rdStat(); wrCtl(8'h40); expect_val(0, 8'h48, "R10 clear master");
    selLevel = 1; cyc(); selLevel = 0; cyc();
    expect_val(0, 8'h48, "R5 disabled no fault");
    selLevel = 1; masterMode = 0; cyc();
    // R8
    txLoad = 1; cyc(); expect_val(0, 8'h40, "R8 txEmpty clears");
    txToShift = 1; cyc(); expect_val(0, 8'h48, "R8 txEmpty sets");
    // R6 error interrupt via overflow
    rxByte(8'h01); rxByte(8'h02);
    expect_val(0, 8'hE8, "R3 overflow 2"); expect_val(1, 8'h01, "R3 keep 01");
    expect_val(2, 8'h03, "R6 both irqs");
    cyc(); cyc();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule